// File: doc/BRIEF.md
# Synchronous Burst Memory with Byte-Lane Writes

This block is a single-clock synchronous memory that loads an address, then walks a four-location burst with an internal 2-bit counter. The data word is split into two byte lanes of equal width. Two separate address-load strobes exist: one meant for a processor and one for a memory controller. They differ in how writes are treated in the load cycle. A step input advances the burst or, when released, holds it. A global write input forces every lane to be written. Otherwise a shared byte-write enable together with per-lane selects picks the lanes.

Any cycle inside a burst that writes nothing is a read. Its data appears one clock later on a registered output. The output is qualified by a driven-flag, which stands in for a tri-state bus. The flag rises only when the read enable is low and the previous cycle was a read. This means write data and read data never meet on the bus.

Top module: `burst_sram`

## Requirements
- R1: The device is selected only when `ce_a_n`=0, `ce_b_n`=0 and `ce_c`=1 on the same edge. A load strobe seen while not selected loads nothing and writes nothing. It also ends the running burst, so later step cycles write nothing until a new load.
- R2: `lda_cpu_n`=0 in a selected cycle loads `addr_i` as the burst base. No lane is written in that cycle, even with `wr_all_n`=0.
- R3: `lda_ctl_n`=0 in a selected cycle loads `addr_i` unless `lda_cpu_n` is also low, in which case the processor strobe wins and no write occurs. The write selects of a controller-load cycle apply to the loaded address.
- R4: In a cycle with no strobe low inside a burst, `step_n`=0 advances the address before the access. Only address bits [1:0] change, in the order 0,1,2,3,0. The upper bits keep their loaded value, and any write goes to the advanced address.
- R5: In a cycle with no strobe low inside a burst, `step_n`=1 holds the address, and any write goes to the held address.
- R6: `wr_all_n`=0 in a write-capable cycle writes both lanes. Lane 0 is data bits [8:0] and lane 1 is bits [17:9]. This holds whatever `wr_lane_en_n` and `wr_lane_n` are.
- R7: With `wr_all_n`=1, lane k is written only when `wr_lane_en_n`=0 and `wr_lane_n[k]`=0. Lanes not written keep their old contents.
- R8: An access cycle that writes no lane is a read. The addressed word appears on `rdata_o` one clock later. `rdata_oe` is 1 only when `rd_en_n`=0 and the previous cycle was such a read, and `rdata_o` is 0 whenever `rdata_oe` is 0.
- R9: A controller-load cycle with `step_n`=0 loads the address but writes nothing.
- R10: After reset no burst is running, so a step cycle writes nothing, and `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b_n | input | 1 | Second chip enable, active low |
| ce_c | input | 1 | Third chip enable, active high |
| lda_cpu_n | input | 1 | Processor address-load strobe, active low |
| lda_ctl_n | input | 1 | Controller address-load strobe, active low |
| step_n | input | 1 | Burst advance, active low; high suspends |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_lane_en_n | input | 1 | Byte-write enable, active low |
| wr_lane_n | input | 2 | Per-lane write selects, active low |
| rd_en_n | input | 1 | Output enable, active low |
| addr_i | input | AW (6) | External address |
| wdata_i | input | 18 | Write data |
| rdata_o | output | 18 | Read data, zero when not driven |
| rdata_oe | output | 1 | Read data is being driven |

## Verification
The bench targets the load cycles themselves. It writes data with the global write low during a processor-strobe load, and with the step input low during a controller-strobe load. A design that wrongly honoured the write would have overwritten data that the final sweep reads back intact. Bursts started at offset 2 must wrap to offset 0 without touching the upper bits; a carry into bit 2 shows up as data landing in the next burst block. Suspended bursts, single-lane writes, a strobe while deselected and steps after reset each leave memory contents that the reference array contradicts if the block steps, writes or holds on the wrong cycle.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int BSR_LANES = 2;
  typedef logic [BSR_LANES-1:0] lane_vec_t;

  // Next burst offset: linear order with wrap.
  function automatic logic [1:0] burst_next(input logic [1:0] ofs);
    return ofs + 2'd1;
  endfunction

  // Lanes requested by the write inputs, before any cycle qualification.
  function automatic lane_vec_t lane_request(input logic gw_n, input logic en_n,
                                             input lane_vec_t sel_n);
    if (!gw_n)      return '1;
    else if (!en_n) return ~sel_n;
    else            return '0;
  endfunction
endpackage

// File: rtl/burst_sram_addr.sv
module burst_sram_addr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          selected,
  input  logic          lda_cpu_n,
  input  logic          lda_ctl_n,
  input  logic          step_n,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] eff_addr,
  output logic          access,
  output logic          wr_ok,
  output logic          ld_ctl
);
  import burst_sram_pkg::*;

  logic [AW-1:0] burst_q;
  logic          active_q;
  logic          ld_cpu, any_strobe, desel_strobe, cont, adv_now, hold_now;

  assign ld_cpu       = selected && !lda_cpu_n;
  assign ld_ctl       = selected && !lda_ctl_n && !ld_cpu;
  assign any_strobe   = !lda_cpu_n || !lda_ctl_n;
  assign desel_strobe = any_strobe && !selected;
  assign cont         = active_q && !any_strobe;
  assign adv_now      = cont && !step_n;
  assign hold_now     = cont && step_n;

  always_comb begin
    if (ld_cpu || ld_ctl) eff_addr = addr_i;
    else if (adv_now)     eff_addr = {burst_q[AW-1:2], burst_next(burst_q[1:0])};
    else                  eff_addr = burst_q;
  end

  assign access = ld_cpu || ld_ctl || cont;
  assign wr_ok  = (ld_ctl && step_n) || cont;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_q  <= '0;
      active_q <= 1'b0;
    end else begin
      if (access) burst_q <= eff_addr;
      if (ld_cpu || ld_ctl)  active_q <= 1'b1;
      else if (desel_strobe) active_q <= 1'b0;
    end
  end

  AST_CPU_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cpu |=> burst_q == $past(addr_i)); // R2
  AST_CTL_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ctl |=> burst_q == $past(addr_i)); // R3
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    adv_now |=> (burst_q[1:0] == $past(burst_q[1:0]) + 2'd1) && (burst_q[AW-1:2] == $past(burst_q[AW-1:2]))); // R4
  AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hold_now |=> $stable(burst_q)); // R5
  AST_DESEL_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    desel_strobe |=> !active_q); // R1
endmodule

// File: rtl/burst_sram_lane.sv
module burst_sram_lane #(
  parameter int AW = 6,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd_q
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    rd_q <= mem[addr];
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int AW     = 6,
  parameter int LANE_W = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce_a_n,
  input  logic                 ce_b_n,
  input  logic                 ce_c,
  input  logic                 lda_cpu_n,
  input  logic                 lda_ctl_n,
  input  logic                 step_n,
  input  logic                 wr_all_n,
  input  logic                 wr_lane_en_n,
  input  logic [1:0]           wr_lane_n,
  input  logic                 rd_en_n,
  input  logic [AW-1:0]        addr_i,
  input  logic [2*LANE_W-1:0]  wdata_i,
  output logic [2*LANE_W-1:0]  rdata_o,
  output logic                 rdata_oe
);
  import burst_sram_pkg::*;
  localparam int DW = BSR_LANES * LANE_W;

  logic          selected, access, wr_ok, ld_ctl, rd_cycle, rd_pend_q;
  logic [AW-1:0] eff_addr;
  lane_vec_t     lane_we;
  logic [DW-1:0] rd_word;

  assign selected = !ce_a_n && !ce_b_n && ce_c;

  burst_sram_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .selected(selected),
    .lda_cpu_n(lda_cpu_n), .lda_ctl_n(lda_ctl_n), .step_n(step_n),
    .addr_i(addr_i), .eff_addr(eff_addr), .access(access),
    .wr_ok(wr_ok), .ld_ctl(ld_ctl)
  );

  assign lane_we  = lane_request(wr_all_n, wr_lane_en_n, wr_lane_n) & {BSR_LANES{access && wr_ok}};
  assign rd_cycle = access && (lane_we == '0);

  for (genvar g = 0; g < BSR_LANES; g++) begin : g_lane
    burst_sram_lane #(.AW(AW), .W(LANE_W)) u_lane (
      .clk(clk), .we(lane_we[g]), .addr(eff_addr),
      .wd(wdata_i[g*LANE_W +: LANE_W]), .rd_q(rd_word[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend_q <= 1'b0;
    else        rd_pend_q <= rd_cycle;
  end

  assign rdata_oe = rd_pend_q && !rd_en_n;
  assign rdata_o  = rdata_oe ? rd_word : '0;

  AST_CPU_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_a_n && !ce_b_n && ce_c && !lda_cpu_n) |-> lane_we == '0); // R2
  AST_CTL_ADV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ctl && !step_n) |-> lane_we == '0); // R9
  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (access && wr_ok && !wr_all_n) |-> lane_we == '1); // R6
  AST_NO_DRIVE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> $past(lane_we == '0)); // R8
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata_o == '0); // R8
endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int N = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic ce_a_n = 1, ce_b_n = 0, ce_c = 1;
  logic lda_cpu_n = 1, lda_ctl_n = 1, step_n = 1;
  logic wr_all_n = 1, wr_lane_en_n = 1, rd_en_n = 1;
  logic [1:0] wr_lane_n = 2'b11;
  logic [AW-1:0] addr_i = '0;
  logic [17:0] wdata_i = '0, rdata_o;
  logic rdata_oe;

  int checks = 0, fails = 0;
  string cur_req = "R10";
  logic [17:0] ref_mem [N];
  int m_addr = 0;
  bit m_act = 0, m_pend = 0;
  logic [17:0] m_rdata = '0;

  always #(CLK_P/2) clk = ~clk;

  burst_sram #(.AW(AW), .LANE_W(9)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_a_n(ce_a_n), .ce_b_n(ce_b_n), .ce_c(ce_c),
    .lda_cpu_n(lda_cpu_n), .lda_ctl_n(lda_ctl_n), .step_n(step_n),
    .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .wr_lane_n(wr_lane_n),
    .rd_en_n(rd_en_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rdata_oe(rdata_oe)
  );

  function automatic logic [17:0] pat(int a, int s);
    return 18'((a * 2467 + s * 911 + 77) & 18'h3ffff);
  endfunction

  task automatic chk(bit ok, string what, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  // One clock: drive, compare outputs with the model, then advance the model.
  task automatic cyc(bit cea, bit ceb, bit cec, bit sp, bit sc, bit adv,
                     bit gw, bit bwe, bit [1:0] bw, bit oe, int a, logic [17:0] d);
    bit sel, lp, lc, strobe, acc, mayw, wr;
    bit [1:0] lanes;
    @(negedge clk);
    ce_a_n = cea; ce_b_n = ceb; ce_c = cec; lda_cpu_n = sp; lda_ctl_n = sc;
    step_n = adv; wr_all_n = gw; wr_lane_en_n = bwe; wr_lane_n = bw;
    rd_en_n = oe; addr_i = AW'(a); wdata_i = d;
    #1;
    chk(rdata_oe == (m_pend && !oe), "rdata_oe", {17'd0, rdata_oe}, {17'd0, m_pend && !oe});
    if (m_pend && !oe) chk(rdata_o == m_rdata, "rdata_o", rdata_o, m_rdata);
    else if (!rdata_oe) chk(rdata_o == 0, "rdata_o idle", rdata_o, 18'd0);
    sel = !cea && !ceb && cec;
    lp = sel && !sp;
    lc = !lp && sel && !sc;
    strobe = !sp || !sc;
    acc = 0; mayw = 0;
    if (lp || lc) begin m_act = 1; m_addr = a; acc = 1; mayw = lc && adv; end
    else if (strobe) m_act = 0;
    else if (m_act) begin
      acc = 1; mayw = 1;
      if (!adv) m_addr = (m_addr & ~3) | ((m_addr + 1) & 3);
    end
    lanes = !gw ? 2'b11 : (!bwe ? ~bw : 2'b00);
    wr = acc && mayw && lanes != 0;
    if (wr) begin
      if (lanes[0]) ref_mem[m_addr][8:0] = d[8:0];
      if (lanes[1]) ref_mem[m_addr][17:9] = d[17:9];
    end
    m_pend = acc && !wr;
    if (m_pend) m_rdata = ref_mem[m_addr];
  endtask

  // Selected-cycle shorthand
  task automatic sc(bit sp, bit sct, bit adv, bit gw, bit bwe, bit [1:0] bw,
                    bit oe, int a, logic [17:0] d);
    cyc(0, 0, 1, sp, sct, adv, gw, bwe, bw, oe, a, d);
  endtask
  task automatic idle_desel();
    cyc(1, 0, 1, 1, 0, 1, 1, 1, 2'b11, 0, 0, 0);
  endtask
  task automatic rd_burst(int base, bit oe);
    sc(0, 1, 1, 1, 1, 2'b11, oe, base, 0);
    for (int k = 0; k < 3; k++) sc(1, 1, 0, 1, 1, 2'b11, oe, 0, 0);
    sc(1, 1, 1, 1, 1, 2'b11, oe, 0, 0);
  endtask

  initial begin
    fork
      begin
        #(CLK_P * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    join_none
    for (int i = 0; i < N; i++) ref_mem[i] = 'x;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: outputs quiet, step cycle without a load writes nothing
    cur_req = "R10";
    cyc(0, 0, 1, 1, 1, 0, 0, 1, 2'b11, 0, 5, 18'h1);
    cyc(0, 0, 1, 1, 1, 1, 0, 1, 2'b11, 0, 5, 18'h2);
    // R6: fill memory with controller-load bursts using global write
    cur_req = "R6";
    for (int b = 0; b < N; b += 4) begin
      sc(1, 0, 1, 0, 1, 2'b11, 1, b, pat(b, 0));
      for (int k = 1; k < 4; k++) sc(1, 1, 0, 0, 1, 2'b11, 1, 0, pat(b + k, 0));
    end
    idle_desel();
    // R2: processor load ignores the global write, the next held cycle writes
    cur_req = "R2";
    sc(0, 1, 1, 0, 0, 2'b00, 1, 8, 18'h3aaaa);
    sc(1, 1, 1, 1, 0, 2'b00, 1, 0, 18'h15555);
    sc(0, 1, 1, 0, 0, 2'b00, 1, 12, 18'h2f0f0);
    idle_desel();
    rd_burst(8, 0); rd_burst(12, 0);
    // R9: controller load with step low writes nothing
    cur_req = "R9";
    sc(1, 0, 0, 0, 1, 2'b11, 1, 17, 18'h0badd);
    idle_desel();
    rd_burst(16, 0);
    // R5: suspended burst writes the held address twice
    cur_req = "R5";
    sc(1, 0, 1, 0, 1, 2'b11, 1, 20, 18'h11111);
    sc(1, 1, 1, 0, 1, 2'b11, 1, 0, 18'h22222);
    sc(1, 1, 0, 0, 1, 2'b11, 1, 0, 18'h33333);
    sc(1, 1, 1, 0, 1, 2'b11, 1, 0, 18'h04444);
    idle_desel();
    rd_burst(20, 0);
    // R4: burst from offset 2 wraps to offset 0 of the same block
    cur_req = "R4";
    sc(1, 0, 1, 0, 1, 2'b11, 1, 26, 18'h0a0a0);
    sc(1, 1, 0, 0, 1, 2'b11, 1, 0, 18'h0b0b0);
    sc(1, 1, 0, 0, 1, 2'b11, 1, 0, 18'h0c0c0);
    sc(1, 1, 0, 0, 1, 2'b11, 1, 0, 18'h0d0d0);
    idle_desel();
    rd_burst(24, 0); rd_burst(28, 0);
    // R7: lane-selective writes
    cur_req = "R7";
    sc(1, 0, 1, 1, 0, 2'b10, 1, 32, 18'h3ffff);
    sc(1, 1, 0, 1, 0, 2'b01, 1, 0, 18'h3ffff);
    sc(1, 1, 0, 1, 1, 2'b00, 1, 0, 18'h3ffff);
    sc(1, 1, 0, 1, 0, 2'b11, 1, 0, 18'h3ffff);
    idle_desel();
    rd_burst(32, 0);
    // R1: strobes while not fully selected
    cur_req = "R1";
    cyc(0, 0, 0, 1, 0, 1, 0, 1, 2'b11, 1, 40, 18'h12345);
    cyc(0, 0, 1, 1, 1, 1, 0, 1, 2'b11, 1, 0, 18'h12345);
    cyc(0, 1, 1, 0, 1, 1, 0, 1, 2'b11, 1, 44, 18'h23456);
    cyc(1, 0, 1, 0, 1, 1, 0, 1, 2'b11, 1, 44, 18'h23456);
    cyc(0, 0, 1, 1, 1, 0, 0, 1, 2'b11, 1, 0, 18'h23456);
    rd_burst(40, 0); rd_burst(44, 0);
    // R3: both strobes low, processor strobe wins; controller write lands
    cur_req = "R3";
    sc(0, 0, 1, 0, 1, 2'b11, 1, 48, 18'h01234);
    idle_desel();
    sc(1, 0, 1, 1, 0, 2'b00, 1, 53, 18'h2468a);
    idle_desel();
    rd_burst(48, 0); rd_burst(52, 0);
    // R8: reads with output disabled stay quiet, then full sweep
    cur_req = "R8";
    rd_burst(0, 1);
    for (int b = 0; b < N; b += 4) rd_burst(b, 0);
    idle_desel();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule